// File: doc/BRIEF.md
# Acquisition Command and Buffer Controller

This controller sits between a host and a streaming spectrum engine. The engine stores raw input samples and computed results in one shared memory. The controller divides that memory into two circular regions. The input region grows upward from address 0. The result region ends at the top address. The host sets the boundary between the two regions while acquisition is halted. It then starts acquisition, stops it and restarts it with single-cycle commands.

While the controller is running, valid-qualified input and result streams are turned into registered memory writes. Each stream has its own pointer, which wraps inside its own region. When the controller is halted, nothing is written. Every accepted start first writes one tag word at the result pointer. The tag holds the new marker count and the low bits of the timestamp, so the host can find where each acquisition interval begins. The host polls four read-only values:

- the result writer's next address,
- a run flag and a sticky error flag,
- a free-running timestamp,
- the marker count.

Top module: `acq_buffer_ctrl`

## Requirements
- R1: After reset:
  - the controller is halted and the error flag is clear;
  - the timestamp and marker count are zero;
  - no write is issued;
  - the result pointer is at the default result start, half of the address range (512 for a 10-bit address).
  - The default input end is one below that.
- R2: A SETUP command (`cmd_op`=1) is accepted while halted only when `cmd_in_end` < `cmd_res_start`. An accepted SETUP loads both bounds, returns the input pointer to 0 and moves the result pointer to the new result start. The new result start is visible on `status_addr` one cycle later.
- R3: A SETUP whose input end is not below its result start, or a SETUP issued while running, changes neither bounds nor pointers. It sets `status_err`, which stays set until reset.
- R4: A START command (`cmd_op`=2) issued while halted does all of the following at the next clock edge:
  - sets the run flag;
  - increments the marker count;
  - issues one write at the current result pointer, with data {new marker count low half, timestamp low half}, where the timestamp is the value seen in the START cycle;
  - advances the result pointer.
- R5: While running, each cycle with `in_valid` and no `res_valid` writes `in_data` at the input pointer one cycle later. The input pointer counts from 0 to the input end and then wraps to 0.
- R6: While running, each cycle with `res_valid` writes `res_data` at the result pointer one cycle later. The result pointer counts from the result start to the top address and then wraps to the result start. When both streams are valid in the same cycle, the result stream takes the port.
- R7: A STOP command (`cmd_op`=3) clears the run flag. Stream data in the STOP cycle, and in every cycle until the next START, produces no write and moves no pointer.
- R8: `status_addr` always equals the address of the next result-region write.
- R9: `timestamp` increments by one every clock after reset, whatever commands arrive.
- R10: A START issued while already running has no effect: no tag write, and the marker count is unchanged.
- R11: Every issued write address lies either at or below the input end or at or above the result start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | 1 = SETUP, 2 = START, 3 = STOP, 0 = none |
| cmd_in_end | input | AW | SETUP: last address of the input region |
| cmd_res_start | input | AW | SETUP: first address of the result region |
| in_valid | input | 1 | Input sample valid |
| in_data | input | DW | Input sample |
| res_valid | input | 1 | Result word valid |
| res_data | input | DW | Result word |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |
| status_addr | output | AW | Next result write address |
| status_run | output | 1 | Acquisition running |
| status_err | output | 1 | Sticky rejected-SETUP flag |
| timestamp | output | TSW | Free-running cycle counter |
| marker_count | output | MW | Number of accepted STARTs |

## Verification
The assertions assume that commands arrive as single-cycle strobes and that reset is held for at least one edge. They rely on the ordering rule that bounds can change only while the controller is halted. That rule is why the region-bounds check can compare each write address with the bounds registered at the moment the write appears.

The stimulus drives both streams, including in the same cycle, and sends every opcode in random order. SETUP values are drawn from the full address range, so rejected bounds, accepted tiny regions and wide regions all occur. Directed steps before the random phase pin down each wrap point, the result-over-input priority, and a START, STOP or SETUP arriving in the wrong state.

// File: rtl/acq_buffer_ctrl.sv
module acq_buffer_ctrl #(
  parameter int AW  = 10,
  parameter int DW  = 32,
  parameter int TSW = 32,
  parameter int MW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  input  logic [1:0]     cmd_op,
  input  logic [AW-1:0]  cmd_in_end,
  input  logic [AW-1:0]  cmd_res_start,
  input  logic           in_valid,
  input  logic [DW-1:0]  in_data,
  input  logic           res_valid,
  input  logic [DW-1:0]  res_data,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  output logic [AW-1:0]  status_addr,
  output logic           status_run,
  output logic           status_err,
  output logic [TSW-1:0] timestamp,
  output logic [MW-1:0]  marker_count
);
  localparam int HW = DW / 2;
  localparam logic [AW-1:0] TOP_ADDR  = {AW{1'b1}};
  localparam logic [AW-1:0] DEF_RES   = {1'b1, {(AW-1){1'b0}}};
  localparam logic [AW-1:0] DEF_INEND = {1'b0, {(AW-1){1'b1}}};
  localparam logic [1:0] OP_SETUP = 2'd1;
  localparam logic [1:0] OP_START = 2'd2;
  localparam logic [1:0] OP_STOP  = 2'd3;

  logic [AW-1:0] in_end_q, res_start_q, in_ptr, res_ptr;
  logic          run_q, err_q;
  logic [TSW-1:0] ts_q;
  logic [MW-1:0]  mk_q;

  wire is_setup = cmd_valid && (cmd_op == OP_SETUP);
  wire is_start = cmd_valid && (cmd_op == OP_START);
  wire is_stop  = cmd_valid && (cmd_op == OP_STOP);

  wire go        = is_start && !run_q;
  wire halt      = is_stop && run_q;
  wire setup_ok  = is_setup && !run_q && (cmd_in_end < cmd_res_start);
  wire setup_bad = is_setup && !setup_ok;
  wire accept    = run_q && !is_stop;
  wire wr_res    = accept && res_valid;
  wire wr_in     = accept && in_valid && !res_valid;

  wire [AW-1:0] in_nxt  = (in_ptr == in_end_q) ? '0 : in_ptr + 1'b1;
  wire [AW-1:0] res_nxt = (res_ptr == TOP_ADDR) ? res_start_q : res_ptr + 1'b1;
  wire [MW-1:0] mk_nxt  = mk_q + 1'b1;
  wire [DW-1:0] tag     = {mk_nxt[HW-1:0], ts_q[HW-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_end_q    <= DEF_INEND;
      res_start_q <= DEF_RES;
      in_ptr      <= '0;
      res_ptr     <= DEF_RES;
      run_q       <= 1'b0;
      err_q       <= 1'b0;
      ts_q        <= '0;
      mk_q        <= '0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
    end else begin
      ts_q   <= ts_q + 1'b1;
      mem_we <= 1'b0;
      if (setup_ok) begin
        in_end_q    <= cmd_in_end;
        res_start_q <= cmd_res_start;
        in_ptr      <= '0;
        res_ptr     <= cmd_res_start;
      end
      if (setup_bad) err_q <= 1'b1;
      if (halt) run_q <= 1'b0;
      if (go) begin
        run_q     <= 1'b1;
        mk_q      <= mk_nxt;
        mem_we    <= 1'b1;
        mem_addr  <= res_ptr;
        mem_wdata <= tag;
        res_ptr   <= res_nxt;
      end else if (wr_res) begin
        mem_we    <= 1'b1;
        mem_addr  <= res_ptr;
        mem_wdata <= res_data;
        res_ptr   <= res_nxt;
      end else if (wr_in) begin
        mem_we    <= 1'b1;
        mem_addr  <= in_ptr;
        mem_wdata <= in_data;
        in_ptr    <= in_nxt;
      end
    end
  end

  assign status_addr  = res_ptr;
  assign status_run   = run_q;
  assign status_err   = err_q;
  assign timestamp    = ts_q;
  assign marker_count = mk_q;

  a_r9_ts_counts: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> timestamp == $past(timestamp) + 1'b1);
  a_r4_start_tags: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> status_run && mem_we && marker_count == $past(marker_count) + 1'b1);
  a_r7_stop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !mem_we && !status_run);
  a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    status_err |=> status_err);
  a_r11_in_region: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr <= in_end_q) || (mem_addr >= res_start_q));
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !status_run && !cmd_valid |=> $stable(status_addr));
  a_r2_setup_loads: assert property (@(posedge clk) disable iff (!rst_n)
    setup_ok |=> status_addr == $past(cmd_res_start));
  a_r10_restart_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    is_start && status_run |=> $stable(marker_count));
endmodule

// File: tb/acq_buffer_ctrl_test.sv
`timescale 1ns/1ps
module acq_buffer_ctrl_test;
  localparam int AW = 10;
  localparam int DW = 32;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, in_valid = 0, res_valid = 0;
  logic [1:0] cmd_op = 0;
  logic [AW-1:0] cmd_in_end = 0, cmd_res_start = 0;
  logic [DW-1:0] in_data = 0, res_data = 0;
  logic mem_we, status_run, status_err;
  logic [AW-1:0] mem_addr, status_addr;
  logic [DW-1:0] mem_wdata;
  logic [31:0] timestamp;
  logic [15:0] marker_count;

  acq_buffer_ctrl #(.AW(AW), .DW(DW), .TSW(32), .MW(16)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_in_end(cmd_in_end), .cmd_res_start(cmd_res_start),
    .in_valid(in_valid), .in_data(in_data), .res_valid(res_valid), .res_data(res_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .status_addr(status_addr), .status_run(status_run), .status_err(status_err),
    .timestamp(timestamp), .marker_count(marker_count));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  bit m_run, m_err;
  logic [AW-1:0] m_ie, m_rs, m_ip, m_rp;
  logic [15:0] m_mk;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] wrap_in(input logic [AW-1:0] p, input logic [AW-1:0] e);
    return (p == e) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [AW-1:0] wrap_res(input logic [AW-1:0] p, input logic [AW-1:0] s);
    return (p == {AW{1'b1}}) ? s : p + 1'b1;
  endfunction

  task automatic step(input bit cv, input logic [1:0] op, input logic [AW-1:0] ie,
                      input logic [AW-1:0] rs, input bit iv, input logic [DW-1:0] id,
                      input bit rv, input logic [DW-1:0] rd);
    logic [31:0] ts_now;
    bit e_we;
    logic [AW-1:0] e_addr;
    logic [DW-1:0] e_data;
    string rq;
    cmd_valid = cv; cmd_op = op; cmd_in_end = ie; cmd_res_start = rs;
    in_valid = iv; in_data = id; res_valid = rv; res_data = rd;
    ts_now = timestamp;
    e_we = 0; e_addr = 0; e_data = 0; rq = "R7";
    if (cv && op == 2'd1) begin
      if (!m_run && ie < rs) begin
        m_ie = ie; m_rs = rs; m_ip = 0; m_rp = rs; rq = "R2";
      end else begin
        m_err = 1; rq = "R3";
      end
    end
    if (cv && op == 2'd2 && !m_run) begin
      m_mk = m_mk + 1'b1;
      e_we = 1; e_addr = m_rp; e_data = {m_mk, ts_now[15:0]};
      m_rp = wrap_res(m_rp, m_rs); m_run = 1; rq = "R4";
    end else if (m_run && !(cv && op == 2'd3)) begin
      if (cv && op == 2'd2) rq = "R10";
      if (rv) begin
        e_we = 1; e_addr = m_rp; e_data = rd; m_rp = wrap_res(m_rp, m_rs);
        if (rq != "R10") rq = "R6";
      end else if (iv) begin
        e_we = 1; e_addr = m_ip; e_data = id; m_ip = wrap_in(m_ip, m_ie);
        if (rq != "R10") rq = "R5";
      end
    end else if (m_run && cv && op == 2'd3) begin
      m_run = 0;
    end
    @(posedge clk);
    @(negedge clk);
    chk(mem_we == e_we, rq, "mem_we", 64'(mem_we), 64'(e_we));
    if (e_we) begin
      chk(mem_addr == e_addr, rq, "mem_addr", 64'(mem_addr), 64'(e_addr));
      chk(mem_wdata == e_data, rq, "mem_wdata", 64'(mem_wdata), 64'(e_data));
      chk((mem_addr <= m_ie) || (mem_addr >= m_rs), "R11", "addr region", 64'(mem_addr), 64'(m_rs));
    end
    chk(status_addr == m_rp, "R8", "status_addr", 64'(status_addr), 64'(m_rp));
    chk(status_run == m_run, rq, "status_run", 64'(status_run), 64'(m_run));
    chk(status_err == m_err, "R3", "status_err", 64'(status_err), 64'(m_err));
    chk(marker_count == m_mk, rq, "marker", 64'(marker_count), 64'(m_mk));
    chk(timestamp == ts_now + 1, "R9", "timestamp", 64'(timestamp), 64'(ts_now + 1));
  endtask

  task automatic idle(input bit iv, input bit rv);
    step(0, 2'd0, '0, '0, iv, $urandom, rv, $urandom);
  endtask

  initial begin
    void'($urandom(32'd1234));
    m_run = 0; m_err = 0; m_ie = 10'd511; m_rs = 10'd512; m_ip = 0; m_rp = 10'd512; m_mk = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!mem_we && !status_run && !status_err, "R1", "flags", {mem_we, status_run, status_err}, 0);
    chk(timestamp == 0, "R1", "timestamp", 64'(timestamp), 0);
    chk(marker_count == 0, "R1", "marker", 64'(marker_count), 0);
    chk(status_addr == 10'd512, "R1", "status_addr", 64'(status_addr), 512);
    rst_n = 1;
    idle(1, 0);
    idle(0, 1);
    step(1, 2'd1, 10'd3, 10'd1020, 0, 0, 0, 0);
    step(1, 2'd2, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) idle(1, 0);
    for (int i = 0; i < 6; i++) idle(0, 1);
    idle(1, 1);
    step(1, 2'd2, 0, 0, 1, 32'hAAAA5555, 0, 0);
    step(1, 2'd1, 10'd1, 10'd2, 0, 0, 0, 0);
    step(1, 2'd3, 0, 0, 1, 32'h1111, 1, 32'h2222);
    idle(1, 0);
    idle(0, 1);
    step(1, 2'd3, 0, 0, 0, 0, 0, 0);
    step(1, 2'd1, 10'd5, 10'd5, 0, 0, 0, 0);
    step(1, 2'd1, 10'd8, 10'd4, 0, 0, 0, 0);
    idle(1, 1);
    step(1, 2'd2, 0, 0, 0, 0, 1, 0);
    idle(0, 1);
    step(1, 2'd3, 0, 0, 0, 0, 0, 0);
    step(1, 2'd1, 10'd0, 10'd1023, 0, 0, 0, 0);
    step(1, 2'd2, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) idle(1, 1);
    for (int i = 0; i < 4; i++) idle(1, 0);
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [AW-1:0] a, b;
      r = $urandom % 100;
      a = $urandom; b = $urandom;
      if (r < 3) step(1, 2'd1, a % 16, b, 0, 0, 0, 0);
      else if (r < 6) step(1, 2'd1, a, b, $urandom % 2, $urandom, 0, 0);
      else if (r < 9) step(1, 2'd2, 0, 0, $urandom % 2, $urandom, $urandom % 2, $urandom);
      else if (r < 11) step(1, 2'd3, 0, 0, $urandom % 2, $urandom, $urandom % 2, $urandom);
      else idle($urandom % 2, ($urandom % 3) == 0);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule